// File: doc/BRIEF.md
# Pulse-Swallow Divider Pair for a PLL Phase Detector

This block supplies the two divided clocks that a phase-locked loop compares. A reference divider counts cycles of the reference clock and emits one single-cycle pulse every R cycles. An LO divider counts cycles of the oscillator clock and emits one single-cycle pulse every P*B+A cycles. The LO divider is built the way a real pulse-swallow synthesizer is. A dual-modulus prescaler, modelled here in logic, divides by P+1 or by P. An 11-bit main counter and a 7-bit swallow counter count the prescaler's output periods. Both pulse trains go to one phase comparator outside this block.

During each LO division cycle the prescaler runs at P+1 while the swallow count is non-zero, and at P for the remaining main-count periods. Then both counters reload together. P is chosen by a select input: the low modulus (16 by default) or the high modulus (32 by default). New ratio and select values are taken only at a division-cycle boundary, so a change never produces a short or long period. A power-enable input holds both dividers idle. A flag warns when the swallow count exceeds the main count, because the P*B+A relation does not hold then.

Each clock domain has its own reset synchronizer and its own enable synchronizer. The reset is asynchronous and active low, and is released synchronously in each domain.

Top module: `swdiv_pair`

## Requirements
- R1: With power enabled, `ref_pulse` rises once every `ref_ratio` cycles of `ref_clk`. A `ref_ratio` of 0 behaves as a ratio of 1.
- R2: With power enabled and 1 <= `main_val`, `swallow_val` <= `main_val`, `lo_pulse` rises once every P*`main_val`+`swallow_val` cycles of `lo_clk`.
- R3: `pre_sel` = 0 makes P equal to parameter PRE_LO (default 16). `pre_sel` = 1 makes P equal to PRE_HI (default 32).
- R4: Inside an LO division cycle, the prescaler modulus is always PRE_LO, PRE_LO+1, PRE_HI or PRE_HI+1. Consecutive LO pulses are at least PRE_LO cycles apart.
- R5: `ratio_bad` is 1 one `lo_clk` cycle after `swallow_val` > `main_val`, and 0 one cycle after `swallow_val` <= `main_val`.
- R6: A change of `ref_ratio`, `swallow_val`, `main_val` or `pre_sel` made inside a division cycle does not alter that cycle's length. The new ratio governs the following cycle.
- R7: While `pwr_en` is low, after its two-stage synchronizer, neither `ref_pulse` nor `lo_pulse` is asserted. Both dividers restart with the current ratios when `pwr_en` returns high.
- R8: While `rst_n` is low, `ref_pulse`, `lo_pulse` and `ratio_bad` are all 0.
- R9: Each `lo_pulse` lasts exactly one `lo_clk` cycle. Each `ref_pulse` lasts one `ref_clk` cycle whenever the ratio is 2 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| lo_clk | input | 1 | Oscillator clock fed to the prescaler model |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_en | input | 1 | Divider power enable, asynchronous |
| ref_ratio | input | REF_W (15) | Reference division ratio R |
| swallow_val | input | SWL_W (7) | Swallow count A |
| main_val | input | MAIN_W (11) | Main count B |
| pre_sel | input | 1 | Prescaler select, 0 = low modulus, 1 = high modulus |
| ref_pulse | output | 1 | One pulse per reference division cycle, in `ref_clk` domain |
| lo_pulse | output | 1 | One pulse per LO division cycle, in `lo_clk` domain |
| ratio_bad | output | 1 | Swallow count exceeds main count |

## Verification
The bench builds the block with PRE_LO = 4 and PRE_HI = 8 and keeps the default counter widths. Total LO ratios are therefore tens to about two thousand cycles. This lets each random or directed ratio be measured over three full division cycles. It also allows a swallow count of 127 against a main count of 200 within the cycle budget. Both prescaler selects are used, along with the ratio-0 and ratio-1 reference cases, mid-cycle ratio changes in both domains and a power-down window.

// File: rtl/swdiv_pkg.sv
package swdiv_pkg;

  // Prescaler modulus choice: low or high base modulus.
  typedef enum logic {
    PRE_NARROW = 1'b0,
    PRE_WIDE   = 1'b1
  } pre_sel_e;

endpackage

// File: rtl/swdiv_sync.sv
// Reset release and enable synchronizer for one clock domain.
module swdiv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic en_async,
  output logic rst_n_s,
  output logic en_s
);

  logic [STAGES-1:0] rst_pipe_q;
  logic [STAGES-1:0] en_pipe_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rst_pipe_q <= '0;
      en_pipe_q  <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[STAGES-2:0], 1'b1};
      en_pipe_q  <= {en_pipe_q[STAGES-2:0], en_async};
    end
  end

  assign rst_n_s = rst_pipe_q[STAGES-1];
  assign en_s    = en_pipe_q[STAGES-1];

endmodule

// File: rtl/swdiv_ref_counter.sv
// Divide-by-R counter. The terminal count is latched at each cycle boundary.
module swdiv_ref_counter #(
  parameter int W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] ratio,
  output logic         pulse
);

  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] term_q, term_d;
  logic [W-1:0] next_term;
  logic         done;
  logic         pulse_q;

  assign next_term = (ratio == '0) ? '0 : ratio - W'(1);

  always_comb begin
    done   = en && (cnt_q == term_q);
    cnt_d  = cnt_q;
    term_d = term_q;
    if (!en || done) begin
      cnt_d  = '0;
      term_d = next_term;
    end else begin
      cnt_d  = cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      term_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      term_q  <= term_d;
      pulse_q <= done;
    end
  end

  assign pulse = pulse_q;

endmodule

// File: rtl/swdiv_prescaler.sv
// Logic model of the dual-modulus prescaler: one tick per modulus cycles.
module swdiv_prescaler #(
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [PW-1:0] modulus,
  output logic          tick
);

  logic [PW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = en && (cnt_q == modulus - PW'(1));
    cnt_d = (!en || tick) ? '0 : cnt_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/swdiv_swallow_ctrl.sv
// Swallow and main counters driving the prescaler modulus.
module swdiv_swallow_ctrl
  import swdiv_pkg::*;
#(
  parameter int AW  = 7,
  parameter int BW  = 11,
  parameter int PW  = 6,
  parameter int PLO = 16,
  parameter int PHI = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] a_val,
  input  logic [BW-1:0] b_val,
  input  logic          sel,
  input  logic          tick,
  output logic [PW-1:0] modulus,
  output logic          pulse
);

  localparam logic [PW-1:0] P_LO_V = PW'(PLO);
  localparam logic [PW-1:0] P_HI_V = PW'(PHI);

  logic [AW-1:0] a_rem_q, a_rem_d;
  logic [BW-1:0] b_rem_q, b_rem_d;
  pre_sel_e      sel_q, sel_d;
  logic [PW-1:0] p_base;
  logic          last, done, pulse_q;

  assign p_base  = (sel_q == PRE_WIDE) ? P_HI_V : P_LO_V;
  assign modulus = p_base + ((a_rem_q != '0) ? PW'(1) : PW'(0));
  assign last    = (b_rem_q <= BW'(1));
  assign done    = en && tick && last;

  always_comb begin
    a_rem_d = a_rem_q;
    b_rem_d = b_rem_q;
    sel_d   = sel_q;
    if (!en || done) begin
      a_rem_d = a_val;
      b_rem_d = b_val;
      sel_d   = pre_sel_e'(sel);
    end else if (tick) begin
      if (a_rem_q != '0) a_rem_d = a_rem_q - AW'(1);
      b_rem_d = b_rem_q - BW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rem_q <= '0;
      b_rem_q <= '0;
      sel_q   <= PRE_NARROW;
      pulse_q <= 1'b0;
    end else begin
      a_rem_q <= a_rem_d;
      b_rem_q <= b_rem_d;
      sel_q   <= sel_d;
      pulse_q <= done;
    end
  end

  assign pulse = pulse_q;

endmodule

// File: rtl/swdiv_pair.sv
// Reference divider and pulse-swallow LO divider for a phase detector.
module swdiv_pair #(
  parameter int REF_W  = 15,
  parameter int SWL_W  = 7,
  parameter int MAIN_W = 11,
  parameter int PRE_LO = 16,
  parameter int PRE_HI = 32
) (
  input  logic              ref_clk,
  input  logic              lo_clk,
  input  logic              rst_n,
  input  logic              pwr_en,
  input  logic [REF_W-1:0]  ref_ratio,
  input  logic [SWL_W-1:0]  swallow_val,
  input  logic [MAIN_W-1:0] main_val,
  input  logic              pre_sel,
  output logic              ref_pulse,
  output logic              lo_pulse,
  output logic              ratio_bad
);

  localparam int PRE_W = $clog2(PRE_HI + 2);
  localparam int CMP_W = (SWL_W > MAIN_W) ? SWL_W : MAIN_W;

  logic             ref_rst_n_s, ref_en_s;
  logic             lo_rst_n_s, lo_en_s;
  logic [PRE_W-1:0] pre_mod;
  logic             pre_tick;
  logic             bad_d, bad_q;

  swdiv_sync #(.STAGES(2)) u_ref_sync (
    .clk      (ref_clk),
    .arst_n   (rst_n),
    .en_async (pwr_en),
    .rst_n_s  (ref_rst_n_s),
    .en_s     (ref_en_s)
  );

  swdiv_sync #(.STAGES(2)) u_lo_sync (
    .clk      (lo_clk),
    .arst_n   (rst_n),
    .en_async (pwr_en),
    .rst_n_s  (lo_rst_n_s),
    .en_s     (lo_en_s)
  );

  swdiv_ref_counter #(.W(REF_W)) u_ref_cnt (
    .clk   (ref_clk),
    .rst_n (ref_rst_n_s),
    .en    (ref_en_s),
    .ratio (ref_ratio),
    .pulse (ref_pulse)
  );

  swdiv_prescaler #(.PW(PRE_W)) u_presc (
    .clk     (lo_clk),
    .rst_n   (lo_rst_n_s),
    .en      (lo_en_s),
    .modulus (pre_mod),
    .tick    (pre_tick)
  );

  swdiv_swallow_ctrl #(
    .AW  (SWL_W),
    .BW  (MAIN_W),
    .PW  (PRE_W),
    .PLO (PRE_LO),
    .PHI (PRE_HI)
  ) u_swallow (
    .clk     (lo_clk),
    .rst_n   (lo_rst_n_s),
    .en      (lo_en_s),
    .a_val   (swallow_val),
    .b_val   (main_val),
    .sel     (pre_sel),
    .tick    (pre_tick),
    .modulus (pre_mod),
    .pulse   (lo_pulse)
  );

  assign bad_d = CMP_W'(swallow_val) > CMP_W'(main_val);

  always_ff @(posedge lo_clk or negedge lo_rst_n_s) begin
    if (!lo_rst_n_s) bad_q <= 1'b0;
    else             bad_q <= bad_d;
  end

  assign ratio_bad = bad_q;

endmodule

// File: rtl/swdiv_pair_chk.sv
// Property checker attached to swdiv_pair.
module swdiv_pair_chk #(
  parameter int SWL_W  = 7,
  parameter int MAIN_W = 11,
  parameter int PRE_LO = 16,
  parameter int PRE_HI = 32,
  parameter int PRE_W  = 6
) (
  input logic              ref_clk,
  input logic              lo_clk,
  input logic              ref_rst_n,
  input logic              lo_rst_n,
  input logic              ref_en,
  input logic              lo_en,
  input logic              ref_pulse,
  input logic              lo_pulse,
  input logic              ratio_bad,
  input logic [SWL_W-1:0]  swallow_val,
  input logic [MAIN_W-1:0] main_val,
  input logic [PRE_W-1:0]  modulus
);

  localparam int CMP_W = (SWL_W > MAIN_W) ? SWL_W : MAIN_W;

  logic [31:0] gap_q;
  logic        seen_q;
  logic        a_gt_b;

  assign a_gt_b = CMP_W'(swallow_val) > CMP_W'(main_val);

  always_ff @(posedge lo_clk or negedge lo_rst_n) begin
    if (!lo_rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (!lo_en) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (lo_pulse) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else begin
      gap_q  <= gap_q + 32'd1;
    end
  end

  // R7: an idle reference divider emits nothing
  a_r7_ref_quiet: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    !ref_en |=> !ref_pulse);

  // R7: an idle LO divider emits nothing
  a_r7_lo_quiet: assert property (@(posedge lo_clk) disable iff (!lo_rst_n)
    !lo_en |=> !lo_pulse);

  // R9: LO pulses are one cycle wide
  a_r9_lo_single: assert property (@(posedge lo_clk) disable iff (!lo_rst_n)
    lo_pulse |=> !lo_pulse);

  // R4: prescaler modulus stays within the four legal values
  a_r4_modulus_legal: assert property (@(posedge lo_clk) disable iff (!lo_rst_n)
    (modulus == PRE_W'(PRE_LO)) || (modulus == PRE_W'(PRE_LO + 1)) ||
    (modulus == PRE_W'(PRE_HI)) || (modulus == PRE_W'(PRE_HI + 1)));

  // R4: consecutive LO pulses are at least PRE_LO cycles apart
  a_r4_min_gap: assert property (@(posedge lo_clk) disable iff (!lo_rst_n)
    (lo_pulse && seen_q) |-> (gap_q >= 32'(PRE_LO - 1)));

  // R5: flag set after an oversized swallow count
  a_r5_flag_set: assert property (@(posedge lo_clk) disable iff (!lo_rst_n)
    a_gt_b |=> ratio_bad);

  // R5: flag cleared after a legal pair
  a_r5_flag_clear: assert property (@(posedge lo_clk) disable iff (!lo_rst_n)
    !a_gt_b |=> !ratio_bad);

endmodule

bind swdiv_pair swdiv_pair_chk #(
  .SWL_W  (SWL_W),
  .MAIN_W (MAIN_W),
  .PRE_LO (PRE_LO),
  .PRE_HI (PRE_HI),
  .PRE_W  (PRE_W)
) u_chk (
  .ref_clk     (ref_clk),
  .lo_clk      (lo_clk),
  .ref_rst_n   (ref_rst_n_s),
  .lo_rst_n    (lo_rst_n_s),
  .ref_en      (ref_en_s),
  .lo_en       (lo_en_s),
  .ref_pulse   (ref_pulse),
  .lo_pulse    (lo_pulse),
  .ratio_bad   (ratio_bad),
  .swallow_val (swallow_val),
  .main_val    (main_val),
  .modulus     (pre_mod)
);

// File: tb/swdiv_pair_bench.sv
`timescale 1ns/1ps
module swdiv_pair_bench;

  localparam int REF_W  = 15;
  localparam int SWL_W  = 7;
  localparam int MAIN_W = 11;
  localparam int PLO    = 4;
  localparam int PHI    = 8;

  logic              ref_clk = 1'b0;
  logic              lo_clk  = 1'b0;
  logic              rst_n;
  logic              pwr_en;
  logic [REF_W-1:0]  ref_ratio;
  logic [SWL_W-1:0]  swallow_val;
  logic [MAIN_W-1:0] main_val;
  logic              pre_sel;
  logic              ref_pulse, lo_pulse, ratio_bad;

  int checks = 0;
  int fails  = 0;
  bit done_run = 1'b0;

  int lo_np = 0, lo_gap = 0, lo_last = 0;
  int rf_np = 0, rf_gap = 0, rf_last = 0;

  always #4 lo_clk  = ~lo_clk;
  always #5 ref_clk = ~ref_clk;

  swdiv_pair #(
    .REF_W(REF_W), .SWL_W(SWL_W), .MAIN_W(MAIN_W), .PRE_LO(PLO), .PRE_HI(PHI)
  ) u_swdiv_pair (
    .ref_clk(ref_clk), .lo_clk(lo_clk), .rst_n(rst_n), .pwr_en(pwr_en),
    .ref_ratio(ref_ratio), .swallow_val(swallow_val), .main_val(main_val),
    .pre_sel(pre_sel), .ref_pulse(ref_pulse), .lo_pulse(lo_pulse),
    .ratio_bad(ratio_bad)
  );

  // Interval monitors, sampled on falling edges
  always @(negedge lo_clk) begin
    lo_gap++;
    if (lo_pulse === 1'b1) begin
      lo_last = lo_gap;
      lo_gap  = 0;
      lo_np++;
    end
  end

  always @(negedge ref_clk) begin
    rf_gap++;
    if (ref_pulse === 1'b1) begin
      rf_last = rf_gap;
      rf_gap  = 0;
      rf_np++;
    end
  end

  function automatic int exp_lo(int sel, int a, int b);
    int p = (sel != 0) ? PHI : PLO;
    return p * b + a;
  endfunction

  function automatic int exp_ref(int r);
    return (r == 0) ? 1 : r;
  endfunction

  task automatic check(string req, int actual, int expected, string what);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, actual, expected);
    end
  endtask

  task automatic wait_lo(int n);
    int start = lo_np;
    while (lo_np < start + n) @(posedge lo_clk);
  endtask

  task automatic wait_ref(int n);
    int start = rf_np;
    while (rf_np < start + n) @(posedge ref_clk);
  endtask

  task automatic set_lo(int sel, int a, int b);
    @(negedge lo_clk);
    pre_sel     = sel[0];
    swallow_val = SWL_W'(a);
    main_val    = MAIN_W'(b);
  endtask

  task automatic check_lo(string req, int sel, int a, int b);
    set_lo(sel, a, b);
    wait_lo(3);
    check(req, lo_last, exp_lo(sel, a, b), "LO period");
  endtask

  task automatic check_ref(string req, int r);
    @(negedge ref_clk);
    ref_ratio = REF_W'(r);
    wait_ref(3);
    check(req, rf_last, exp_ref(r), "reference period");
  endtask

  task automatic finish_run();
    if (!done_run) begin
      done_run = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge lo_clk);
    fails++;
    $display("FAIL R2 watchdog: actual=hung expected=complete");
    finish_run();
  end

  initial begin
    int sel, a, b, r, np0, rp0;
    void'($urandom(32'd4633));
    rst_n = 1'b0; pwr_en = 1'b0;
    ref_ratio = '0; swallow_val = '0; main_val = '0; pre_sel = 1'b0;
    repeat (5) @(posedge lo_clk);
    @(negedge lo_clk);
    // R8: reset state
    check("R8", int'(lo_pulse),  0, "lo_pulse in reset");
    check("R8", int'(ref_pulse), 0, "ref_pulse in reset");
    check("R8", int'(ratio_bad), 0, "ratio_bad in reset");
    ref_ratio = REF_W'(5); swallow_val = SWL_W'(1); main_val = MAIN_W'(3);
    rst_n = 1'b1;
    pwr_en = 1'b1;

    // R2 R3: directed LO ratios, both prescaler selects
    check_lo("R2", 0, 0, 1);
    check_lo("R2", 0, 3, 5);
    check_lo("R3", 1, 3, 5);
    check_lo("R3", 1, 0, 7);
    check_lo("R2", 1, 6, 6);
    check_lo("R2", 1, 127, 200);

    // R9: pulse width of one cycle
    wait_lo(1);
    @(negedge lo_clk);
    check("R9", int'(lo_pulse), 0, "lo_pulse cycle after pulse");

    // R1: reference ratios, including 0 and 1
    check_ref("R1", 0);
    check_ref("R1", 1);
    check_ref("R1", 2);
    check_ref("R1", 37);
    wait_ref(1);
    @(negedge ref_clk);
    check("R9", int'(ref_pulse), 0, "ref_pulse cycle after pulse");

    // R5: invalid ratio flag
    set_lo(0, 9, 3);
    repeat (3) @(negedge lo_clk);
    check("R5", int'(ratio_bad), 1, "flag with A>B");
    set_lo(0, 3, 9);
    repeat (3) @(negedge lo_clk);
    check("R5", int'(ratio_bad), 0, "flag with A<=B");

    // R6: mid-cycle LO change keeps the running cycle
    check_lo("R6", 0, 4, 10);
    wait_lo(1);
    repeat (5) @(posedge lo_clk);
    set_lo(1, 2, 3);
    wait_lo(1);
    check("R6", lo_last, exp_lo(0, 4, 10), "LO cycle spanning change");
    wait_lo(1);
    check("R6", lo_last, exp_lo(1, 2, 3), "LO cycle after change");

    // R6: mid-cycle reference change keeps the running cycle
    check_ref("R6", 30);
    wait_ref(1);
    repeat (4) @(posedge ref_clk);
    @(negedge ref_clk);
    ref_ratio = REF_W'(7);
    wait_ref(1);
    check("R6", rf_last, 30, "ref cycle spanning change");
    wait_ref(1);
    check("R6", rf_last, 7, "ref cycle after change");

    // R7: power down silences both outputs
    @(negedge lo_clk);
    pwr_en = 1'b0;
    repeat (6) @(posedge lo_clk);
    np0 = lo_np; rp0 = rf_np;
    repeat (300) @(posedge lo_clk);
    check("R7", lo_np - np0, 0, "LO pulses while disabled");
    check("R7", rf_np - rp0, 0, "ref pulses while disabled");
    @(negedge lo_clk);
    pwr_en = 1'b1;
    check_lo("R7", 0, 2, 4);
    check_ref("R7", 9);

    // R2 R3 R1: constrained random ratios
    for (int i = 0; i < 16; i++) begin
      sel = int'($urandom % 2);
      b   = 1 + int'($urandom % 14);
      a   = int'($urandom % (b + 1));
      check_lo((sel != 0) ? "R3" : "R2", sel, a, b);
      r   = int'($urandom % 50);
      check_ref("R1", r);
    end

    finish_run();
  end

endmodule